// File: doc/BRIEF.md
# Sliding Register Window File

This block is the general-purpose register file of a processor core that uses overlapping register windows. The core always addresses 32 logical registers with 5-bit numbers. Underneath, those numbers map onto a larger circular physical array through a current-window pointer. A procedure call moves the pointer forward one window and a return moves it back. Each move takes a single clock edge and copies no data.

Adjacent windows overlap. The eight registers a caller uses to pass arguments become the callee's eight incoming registers. The results the callee leaves there are still visible to the caller after the return. Eight global registers sit outside the windows. Interrupt entry behaves like a call, so a handler gets a fresh window without saving anything.

The file keeps a count of live windows. A call that would reuse a window still in use is refused, and the block raises an overflow flag. A return with no caller window is also refused, and the block raises an underflow flag. In both cases the core's trap logic is expected to spill or refill windows to memory. There are two registered read ports and one write port. A write is forwarded to a read of the same register in the same cycle.

Top module: `rwf_regfile`

## Requirements
- R1: After synchronous reset the window pointer is 0, one window is live, both flags are low and both read data outputs are 0.
- R2: Logical registers 1 to 7 are global: a value written in any window is read back unchanged in every other window.
- R3: After a successful call, logical registers 8 to 15 of the new window read the values the caller holds in its registers 24 to 31. A write to one of them is seen by the caller in the same register after the return.
- R4: Logical registers 16 to 23 belong to one window only: writing them in a callee leaves the caller's registers 16 to 23 unchanged.
- R5: A call or return strobe sampled at a clock edge takes effect at that edge. A read or write issued in the next cycle already uses the new window, while one issued in the strobe cycle uses the old window.
- R6: An interrupt-entry strobe has exactly the same effect as a call strobe, including overflow detection.
- R7: With 8 windows, at most 7 can be live. A call or interrupt entry while 7 are live leaves the window unchanged and drives the overflow flag high for the following cycle only.
- R8: A return while only one window is live leaves the window unchanged and drives the underflow flag high for the following cycle only.
- R9: When the read and write ports name the same logical register in the same cycle, the read returns the data being written.
- R10: Logical register 0 always reads as 0, and writes to it have no effect.
- R11: Read data appears on the output one clock after the read index is presented, and holds until the next edge.
- R12: If a call (or interrupt entry) and a return are strobed together, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Logical register number, read port A |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_idx | input | 5 | Logical register number, read port B |
| rd_b_data | output | 32 | Registered read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call: advance one window |
| ret_i | input | 1 | Procedure return: go back one window |
| irq_i | input | 1 | Interrupt entry: advance one window like a call |
| overflow_o | output | 1 | One-cycle pulse: call refused, no free window |
| underflow_o | output | 1 | One-cycle pulse: return refused, no caller window |

## Verification
The bench uses a stack of frames as its model and compares both read ports and both flags after every clock. Directed runs write the outgoing registers, call, and read the incoming registers. This separates a correct overlap from an off-by-one window mapping and from locals leaking into the next window. Globals are read back from deep windows, so a mapping that makes them window-relative is caught. Runs that fill the file to seven windows and then drain it to one find overflow and underflow thresholds that are set one window off. The same runs show whether a refused move still shifts the pointer. A random mix of calls, returns, interrupts, simultaneous strobes and same-cycle read/write pairs covers the priority and bypass paths.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef enum logic [1:0] {
    WOP_HOLD = 2'd0,
    WOP_CALL = 2'd1,
    WOP_RET  = 2'd2
  } win_op_e;
endpackage

// File: rtl/rwf_window_ctrl.sv
module rwf_window_ctrl #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN),
  localparam int OW  = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_i,
  output logic [CW-1:0] cwp,
  output logic [OW-1:0] occ,
  output logic          overflow_o,
  output logic          underflow_o
);
  import rwf_pkg::*;

  win_op_e op;
  logic    ovf, udf;

  // call and interrupt entry outrank a return (R12, R6)
  always_comb begin
    if (call_i || irq_i) op = WOP_CALL;
    else if (ret_i)      op = WOP_RET;
    else                 op = WOP_HOLD;
  end

  assign ovf = (op == WOP_CALL) && (occ == OW'(NWIN - 1));
  assign udf = (op == WOP_RET)  && (occ == OW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp         <= '0;
      occ         <= OW'(1);
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= ovf;
      underflow_o <= udf;
      if (op == WOP_CALL && !ovf) begin
        cwp <= cwp + CW'(1);
        occ <= occ + OW'(1);
      end else if (op == WOP_RET && !udf) begin
        cwp <= cwp - CW'(1);
        occ <= occ - OW'(1);
      end
    end
  end
endmodule

// File: rtl/rwf_map.sv
module rwf_map #(
  parameter int NWIN  = 8,
  parameter int GRP   = 8,
  localparam int LW   = $clog2(4 * GRP),
  localparam int CW   = $clog2(NWIN),
  localparam int NPHY = GRP + NWIN * 2 * GRP,
  localparam int PW   = $clog2(NPHY)
) (
  input  logic [CW-1:0] cwp,
  input  logic [LW-1:0] lidx,
  output logic [PW-1:0] phys
);
  logic [CW-1:0] slot;
  logic [PW-1:0] off;

  always_comb begin
    slot = cwp;
    off  = '0;
    if (lidx < LW'(GRP)) begin
      phys = PW'(lidx);
    end else begin
      if (lidx < LW'(2 * GRP)) begin
        // incoming group lives in the caller's slot, upper half
        slot = cwp - CW'(1);
        off  = PW'(lidx);
      end else begin
        off  = PW'(lidx) - PW'(2 * GRP);
      end
      phys = PW'(GRP) + PW'(slot) * PW'(2 * GRP) + off;
    end
  end
endmodule

// File: rtl/rwf_storage.sv
module rwf_storage #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int NRD   = 2,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [PW-1:0]          wa,
  input  logic [DW-1:0]          wd,
  input  logic [NRD-1:0][PW-1:0] ra,
  input  logic [NRD-1:0]         rz,
  output logic [NRD-1:0][DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst || rz[p])             rd[p] <= '0;
      else if (we && wa == ra[p])   rd[p] <= wd;
      else                          rd[p] <= mem[ra[p]];
    end
  end
endmodule

// File: rtl/rwf_regfile.sv
module rwf_regfile #(
  parameter int NWIN  = 8,
  parameter int GRP   = 8,
  parameter int DW    = 32,
  localparam int LW   = $clog2(4 * GRP),
  localparam int CW   = $clog2(NWIN),
  localparam int OW   = $clog2(NWIN + 1),
  localparam int NPHY = GRP + NWIN * 2 * GRP,
  localparam int PW   = $clog2(NPHY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [LW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_i,
  output logic          overflow_o,
  output logic          underflow_o
);
  logic [CW-1:0]        cwp;
  logic [OW-1:0]        occ;
  logic [2:0][LW-1:0]   lidx;
  logic [2:0][PW-1:0]   pidx;
  logic [1:0][PW-1:0]   ra;
  logic [1:0]           rz;
  logic [1:0][DW-1:0]   rd;

  rwf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i),
    .cwp(cwp), .occ(occ), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  assign lidx[0] = rd_a_idx;
  assign lidx[1] = rd_b_idx;
  assign lidx[2] = wr_idx;

  for (genvar i = 0; i < 3; i++) begin : g_map
    rwf_map #(.NWIN(NWIN), .GRP(GRP)) u_map (
      .cwp(cwp), .lidx(lidx[i]), .phys(pidx[i])
    );
  end

  assign ra[0] = pidx[0];
  assign ra[1] = pidx[1];
  assign rz[0] = (rd_a_idx == '0);
  assign rz[1] = (rd_b_idx == '0);

  rwf_storage #(.DW(DW), .DEPTH(NPHY), .NRD(2)) u_mem (
    .clk(clk), .rst(rst),
    .we(wr_en && (wr_idx != '0)), .wa(pidx[2]), .wd(wr_data),
    .ra(ra), .rz(rz), .rd(rd)
  );

  assign rd_a_data = rd[0];
  assign rd_b_data = rd[1];
endmodule

// File: rtl/rwf_regfile_chk.sv
module rwf_regfile_chk #(
  parameter int NWIN = 8,
  parameter int LW   = 5,
  parameter int DW   = 32,
  localparam int CW  = $clog2(NWIN),
  localparam int OW  = $clog2(NWIN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          call_i,
  input logic          ret_i,
  input logic          irq_i,
  input logic          overflow_o,
  input logic          underflow_o,
  input logic [CW-1:0] cwp,
  input logic [OW-1:0] occ,
  input logic [LW-1:0] rd_a_idx,
  input logic [DW-1:0] rd_a_data
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cwp == '0 && occ == OW'(1)));

  p_occ_range_r7: assert property (@(posedge clk) disable iff (rst)
    (occ >= OW'(1) && occ <= OW'(NWIN - 1)));

  p_call_step_r5: assert property (@(posedge clk) disable iff (rst)
    ((call_i || irq_i) && occ != OW'(NWIN - 1))
      |=> (cwp == $past(cwp) + CW'(1) && occ == $past(occ) + OW'(1) && !overflow_o));

  p_ret_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && !irq_i && occ != OW'(1))
      |=> (cwp == $past(cwp) - CW'(1) && !underflow_o));

  p_no_overflow_move_r7: assert property (@(posedge clk) disable iff (rst)
    ((call_i || irq_i) && occ == OW'(NWIN - 1)) |=> (overflow_o && $stable(cwp)));

  p_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && !irq_i && occ == OW'(1)) |=> (underflow_o && $stable(cwp)));

  p_call_wins_r12: assert property (@(posedge clk) disable iff (rst)
    ((call_i || irq_i) && ret_i) |=> !underflow_o);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow_o, underflow_o}));

  p_zero_reg_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |=> (rd_a_data == '0));
endmodule

bind rwf_regfile rwf_regfile_chk #(.NWIN(NWIN), .LW(LW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .cwp(cwp), .occ(occ),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data)
);

// File: tb/tb_rwf_regfile.sv
`timescale 1ns/1ps
module tb_rwf_regfile;
  localparam int NWIN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0, irq_i = 1'b0;
  logic        overflow_o, underflow_o;

  always #4 clk = ~clk;

  rwf_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // model: stack of frames; frame k's incoming group = frame k-1's outgoing group
  int          depth;
  logic [31:0] g   [8];   bit gv  [8];
  logic [31:0] bi  [8];   bit biv [8];
  logic [31:0] loc [7][8]; bit lv [7][8];
  logic [31:0] outr[7][8]; bit ov [7][8];
  int unsigned lfsr = 32'h1234_5678;

  function automatic int unsigned rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic get(int lr, output logic [31:0] v, output bit k);
    v = '0; k = 1;
    if (lr == 0) begin v = '0; k = 1; end
    else if (lr < 8)  begin v = g[lr]; k = gv[lr]; end
    else if (lr < 16) begin
      if (depth > 0) begin v = outr[depth-1][lr-8]; k = ov[depth-1][lr-8]; end
      else begin v = bi[lr-8]; k = biv[lr-8]; end
    end
    else if (lr < 24) begin v = loc[depth][lr-16]; k = lv[depth][lr-16]; end
    else begin v = outr[depth][lr-24]; k = ov[depth][lr-24]; end
  endtask

  task automatic put(int lr, logic [31:0] v);
    if (lr == 0) return;
    if (lr < 8) begin g[lr] = v; gv[lr] = 1; end
    else if (lr < 16) begin
      if (depth > 0) begin outr[depth-1][lr-8] = v; ov[depth-1][lr-8] = 1; end
      else begin bi[lr-8] = v; biv[lr-8] = 1; end
    end
    else if (lr < 24) begin loc[depth][lr-16] = v; lv[depth][lr-16] = 1; end
    else begin outr[depth][lr-24] = v; ov[depth][lr-24] = 1; end
  endtask

  task automatic model_reset();
    depth = 0;
    for (int i = 0; i < 8; i++) begin
      gv[i] = 0; biv[i] = 0;
      for (int d = 0; d < 7; d++) begin lv[d][i] = 0; ov[d][i] = 0; end
    end
  endtask

  // one cycle: drive at negedge, compare one clock later (R11)
  task automatic step(bit c, bit r, bit q, bit we, int wi, logic [31:0] wd,
                      int ra, int rb, string tag);
    logic [31:0] ea, eb; bit ka, kb, eo, eu, go_call;
    call_i = c; ret_i = r; irq_i = q; wr_en = we;
    wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    get(ra, ea, ka); get(rb, eb, kb);
    if (we && wi != 0 && wi == ra) begin ea = wd; ka = 1; end
    if (we && wi != 0 && wi == rb) begin eb = wd; kb = 1; end
    go_call = c || q;
    eo = go_call && (depth == NWIN - 2);
    eu = !go_call && r && (depth == 0);
    @(posedge clk); @(negedge clk);
    if (ka) chk(rd_a_data == ea, {tag, " port A"}, rd_a_data, ea);
    if (kb) chk(rd_b_data == eb, {tag, " port B"}, rd_b_data, eb);
    chk(overflow_o == eo,  "R7 overflow flag",  32'(overflow_o),  32'(eo));
    chk(underflow_o == eu, "R8 underflow flag", 32'(underflow_o), 32'(eu));
    if (we) put(wi, wd);
    if (go_call && !eo) begin
      depth++;
      for (int i = 0; i < 8; i++) begin lv[depth][i] = 0; ov[depth][i] = 0; end
    end else if (!go_call && r && !eu) depth--;
    call_i = 0; ret_i = 0; irq_i = 0; wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(rd_a_data == 0 && rd_b_data == 0, "R1 read data", rd_a_data, 0);
    chk(!overflow_o && !underflow_o, "R1 flags", 32'({overflow_o, underflow_o}), 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, "R1 empty return");

    // R10: register 0
    step(0, 0, 0, 1, 0, 32'hdead_beef, 0, 0, "R10 write r0");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10 read r0");
    // R2: globals and R9 bypass
    for (int i = 1; i < 8; i++)
      step(0, 0, 0, 1, i, 32'h100 + 32'(i), i, 0, "R9 global bypass");
    // outgoing + locals of window 0, incoming of window 0
    for (int i = 8; i < 32; i++)
      step(0, 0, 0, 1, i, 32'hA000 + 32'(i), i - 1, i, "R9 fill window 0");
    // R5: call then read incoming in the next cycle
    step(1, 0, 0, 0, 0, 0, 24, 16, "R5 strobe cycle uses old window");
    for (int i = 8; i < 16; i++)
      step(0, 0, 0, 0, 0, 0, i, i - 7, "R3 overlap and R2 globals");
    for (int i = 16; i < 32; i++)
      step(0, 0, 0, 1, i, 32'hB000 + 32'(i), i, 3, "R4 callee private fill");
    step(0, 0, 0, 1, 9, 32'h5555_0009, 9, 0, "R3 callee writes incoming");
    // R6: interrupt entry acts as a call, fill up to overflow
    step(0, 0, 1, 0, 0, 0, 8, 24, "R6 irq entry");
    for (int i = 8; i < 16; i++) step(0, 0, 0, 0, 0, 0, i, 5, "R6 overlap after irq");
    for (int n = 0; n < 4; n++) step(1, 0, 0, 1, 17, 32'(n), 17, 1, "R7 climb");
    step(1, 0, 0, 0, 0, 0, 17, 0, "R7 call at full");
    step(0, 0, 1, 0, 0, 0, 17, 8, "R7 irq at full");
    step(0, 0, 0, 0, 0, 0, 17, 0, "R7 window unchanged");
    // drain to underflow
    for (int n = 0; n < 6; n++) step(0, 1, 0, 0, 0, 0, 16 + n, 24 + n, "R4 drain");
    for (int i = 16; i < 32; i++) step(0, 0, 0, 0, 0, 0, i, i - 8, "R3 R4 back in window 0");
    step(0, 1, 0, 0, 0, 0, 25, 17, "R8 return at bottom");
    step(0, 0, 0, 0, 0, 0, 25, 17, "R8 window unchanged");
    // R12: simultaneous strobes
    step(1, 1, 0, 0, 0, 0, 0, 0, "R12 call and return");
    step(0, 0, 0, 0, 0, 0, 8, 15, "R12 call took effect");
    step(0, 1, 1, 0, 0, 0, 0, 0, "R12 irq and return");
    step(0, 0, 0, 0, 0, 0, 8, 16, "R12 irq took effect");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned x = rnd();
      int op = int'(x % 10);
      step(op == 0 || op == 7, op == 1 || op == 2 || op == 7, op == 3,
           x[8], int'(x[13:9]), rnd(), int'(x[18:14]), int'(x[23:19]), "R11 random mix");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule